// File: doc/BRIEF.md
# Dual-Potentiometer Register Bank and Transfer Engine

This block holds the stored settings for two digitally controlled potentiometers. Each pot owns four small data registers of wiper width. A bus decoder, which sits outside this block, hands over one completed command at a time with a single-cycle strobe. The strobe is raised once the bus command has been closed by its stop condition. The block then serves register reads, host writes into a register, and transfers between the registers and the wiper counters of one pot or of both pots together. The wiper counters sit outside the block, so the block takes their present values as inputs and issues load requests to them.

Every command that changes a stored register is treated as a slow nonvolatile write. The new value is parked in a pending buffer and a programmable cycle counter starts. A busy flag stays high for the whole window, and the register changes only when the window closes. While busy is high, the block discards every incoming command. At reset the registers take their contents from a parameter vector. The load outputs present register 0 of each pot, so the wiper counters can recall it on power-up.

Top module: `potbank_xfer`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge after it goes high, `ld_req` is all ones, each `ld_val` slice carries its own pot's register 0, and `busy` and `rd_valid` are 0. Register r of pot p resets to `INIT_REGS[(p*NUM_REGS+r)*WIPER_W +: WIPER_W]`.
- R2: A strobe with `cmd_op` = 0 (read) while not busy makes `rd_valid` 1 in the next cycle, with `rd_data` equal to register `cmd_reg` of pot `cmd_pot`.
- R3: A strobe with `cmd_op` = 1 (host write) while not busy stores `cmd_wdata` into register `cmd_reg` of pot `cmd_pot` only. `busy` is high for exactly `WR_CYCLES` cycles, starting in the cycle after the strobe. The register takes its new value on the edge where `busy` falls, so a read issued once `busy` is low returns the new value. No other register changes.
- R4: A strobe with `cmd_op` = 2 (register to wiper, one pot) while not busy raises only bit `cmd_pot` of `ld_req` for one cycle. The matching `ld_val` slice equals that pot's register `cmd_reg`. `busy` stays low.
- R5: A strobe with `cmd_op` = 3 (wiper to register, one pot) while not busy captures slice `cmd_pot` of `wip_cur` in the strobe cycle. It stores that value into register `cmd_reg` of that pot, using the timed window of R3. Later changes of `wip_cur` have no effect.
- R6: A strobe with `cmd_op` = 4 (register to wiper, both pots) while not busy raises both `ld_req` bits for one cycle. Each slice of `ld_val` carries register `cmd_reg` of its own pot. `cmd_pot` is ignored.
- R7: A strobe with `cmd_op` = 5 (wiper to register, both pots) while not busy stores each pot's own `wip_cur` slice into that pot's register `cmd_reg`, using one timed window as in R3.
- R8: A strobe that arrives while `busy` is high is ignored. It produces no `rd_valid` and no `ld_req`, it does not lengthen the window, and it changes no register.
- R9: Strobes with `cmd_op` = 6 or 7 are ignored. They produce no `rd_valid`, no `ld_req` and no `busy`, and they change no register.
- R10: `rd_data` holds its value in every cycle in which `rd_valid` is 0. An `ld_val` slice keeps its value until its own `ld_req` bit is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserted asynchronously, released synchronously to `clk` upstream |
| cmd_valid | input | 1 | One-cycle strobe for a completed bus command |
| cmd_op | input | 3 | Operation code (0 read, 1 write, 2 register to wiper, 3 wiper to register, 4 and 5 the two-pot forms of 2 and 3) |
| cmd_pot | input | POT_W | Pot select |
| cmd_reg | input | REG_W | Data register select |
| cmd_wdata | input | WIPER_W | Host data for a write |
| wip_cur | input | NUM_POTS*WIPER_W | Present wiper counter values, pot 0 in the low slice |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | WIPER_W | Read data |
| ld_req | output | NUM_POTS | Per-pot wiper counter load request |
| ld_val | output | NUM_POTS*WIPER_W | Per-pot load value, pot 0 in the low slice |
| busy | output | 1 | Nonvolatile write window in progress |

## Verification
A wrong pending buffer or index shows up only after the window has closed, when the next read of the target register returns a stale or misplaced value. The bench therefore reads the written register and its neighbours in the other pot right after `busy` falls. A counter that is off by one shows at once as a wrong count of busy cycles. A command that leaks through the busy window appears one cycle later as a stray `rd_valid` or `ld_req` pulse, or later as a changed register. A decode error in the load path shows in the cycle after the strobe, as the wrong `ld_req` bits or a wrong `ld_val` slice.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

  typedef enum logic [2:0] {
    PB_OP_READ      = 3'd0,
    PB_OP_WRITE     = 3'd1,
    PB_OP_REG2WIP   = 3'd2,
    PB_OP_WIP2REG   = 3'd3,
    PB_OP_G_REG2WIP = 3'd4,
    PB_OP_G_WIP2REG = 3'd5
  } pb_op_e;

  function automatic logic pb_is_nv(input logic [2:0] op);
    return (op == PB_OP_WRITE) || (op == PB_OP_WIP2REG) || (op == PB_OP_G_WIP2REG);
  endfunction

  function automatic logic pb_is_load(input logic [2:0] op);
    return (op == PB_OP_REG2WIP) || (op == PB_OP_G_REG2WIP);
  endfunction

endpackage

// File: rtl/potbank_regs.sv
module potbank_regs #(
  parameter int WIDTH = 6,
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter logic [DEPTH*WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] cell_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[i] <= INIT[i*WIDTH +: WIDTH];
      end else if (cell_we) begin
        cell_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = cell_q[rd_idx];

endmodule

// File: rtl/potbank_nvtimer.sv
module potbank_nvtimer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(CYCLES - 1);
        cnt_en = 1'b1;
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/potbank_xfer.sv
module potbank_xfer
  import potbank_pkg::*;
#(
  parameter int NUM_POTS  = 2,
  parameter int WIPER_W   = 6,
  parameter int NUM_REGS  = 4,
  parameter int WR_CYCLES = 64,
  parameter logic [NUM_POTS*NUM_REGS*WIPER_W-1:0] INIT_REGS = '0,
  localparam int POT_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
  localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [2:0]                  cmd_op,
  input  logic [POT_W-1:0]            cmd_pot,
  input  logic [REG_W-1:0]            cmd_reg,
  input  logic [WIPER_W-1:0]          cmd_wdata,
  input  logic [NUM_POTS*WIPER_W-1:0] wip_cur,
  output logic                        rd_valid,
  output logic [WIPER_W-1:0]          rd_data,
  output logic [NUM_POTS-1:0]         ld_req,
  output logic [NUM_POTS*WIPER_W-1:0] ld_val,
  output logic                        busy
);

  localparam int BANK_BITS = NUM_REGS * WIPER_W;

  logic accept;
  logic op_read, op_write, op_r2w, op_w2r, op_gr2w, op_gw2r;
  logic nv_start, nv_busy, nv_done;

  logic [WIPER_W-1:0] rd_pot [NUM_POTS];

  logic [REG_W-1:0]   pend_idx_q;
  logic               rd_valid_q, rd_valid_d;
  logic [WIPER_W-1:0] rd_data_q, rd_data_d;
  logic               rd_en;

  // command decode
  always_comb begin
    accept   = cmd_valid && !nv_busy;
    op_read  = (cmd_op == PB_OP_READ);
    op_write = (cmd_op == PB_OP_WRITE);
    op_r2w   = (cmd_op == PB_OP_REG2WIP);
    op_w2r   = (cmd_op == PB_OP_WIP2REG);
    op_gr2w  = (cmd_op == PB_OP_G_REG2WIP);
    op_gw2r  = (cmd_op == PB_OP_G_WIP2REG);
    nv_start = accept && pb_is_nv(cmd_op);
  end

  potbank_nvtimer #(
    .CYCLES (WR_CYCLES)
  ) nvtimer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (nv_start),
    .busy  (nv_busy),
    .done  (nv_done)
  );

  // per-pot storage, pending write and load path
  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    logic               pot_sel;
    logic               pend_we_q, pend_we_d;
    logic [WIPER_W-1:0] pend_dat_q, pend_dat_d;
    logic               ld_q, ld_d;
    logic [WIPER_W-1:0] ldv_q;
    logic [WIPER_W-1:0] rd_w;

    potbank_regs #(
      .WIDTH (WIPER_W),
      .DEPTH (NUM_REGS),
      .IDX_W (REG_W),
      .INIT  (INIT_REGS[p*BANK_BITS +: BANK_BITS])
    ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (nv_done && pend_we_q),
      .wr_idx  (pend_idx_q),
      .wr_data (pend_dat_q),
      .rd_idx  (cmd_reg),
      .rd_data (rd_w)
    );

    always_comb begin
      pot_sel    = (cmd_pot == POT_W'(p));
      pend_we_d  = ((op_write || op_w2r) && pot_sel) || op_gw2r;
      pend_dat_d = op_write ? cmd_wdata : wip_cur[p*WIPER_W +: WIPER_W];
      ld_d       = accept && ((op_r2w && pot_sel) || op_gr2w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_we_q  <= 1'b0;
        pend_dat_q <= '0;
      end else if (nv_start) begin
        pend_we_q  <= pend_we_d;
        pend_dat_q <= pend_dat_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ld_q <= 1'b1;
      end else begin
        ld_q <= ld_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ldv_q <= INIT_REGS[p*BANK_BITS +: WIPER_W];
      end else if (ld_d) begin
        ldv_q <= rd_w;
      end
    end

    assign rd_pot[p]                     = rd_w;
    assign ld_req[p]                     = ld_q;
    assign ld_val[p*WIPER_W +: WIPER_W] = ldv_q;
  end

  // read return path
  always_comb begin
    rd_en      = accept && op_read;
    rd_valid_d = rd_en;
    rd_data_d  = rd_pot[cmd_pot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idx_q <= '0;
    end else if (nv_start) begin
      pend_idx_q <= cmd_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign busy     = nv_busy;

endmodule

// File: rtl/potbank_xfer_chk.sv
module potbank_xfer_chk
  import potbank_pkg::*;
#(
  parameter int NUM_POTS  = 2,
  parameter int WIPER_W   = 6,
  parameter int WR_CYCLES = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [2:0]          cmd_op,
  input logic                busy,
  input logic                rd_valid,
  input logic [WIPER_W-1:0]  rd_data,
  input logic [NUM_POTS-1:0] ld_req
);

  logic        acc, nv_cmd, ld_cmd, rd_cmd, bad_cmd;
  logic [31:0] run_cnt;

  always_comb begin
    acc     = cmd_valid && !busy;
    nv_cmd  = acc && pb_is_nv(cmd_op);
    ld_cmd  = acc && pb_is_load(cmd_op);
    rd_cmd  = acc && (cmd_op == PB_OP_READ);
    bad_cmd = acc && (cmd_op > 3'd5);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> rd_valid); // R2

  AST_NV_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nv_cmd |=> busy); // R3

  AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == 32'(WR_CYCLES))); // R3

  AST_LOAD_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cmd |=> !busy); // R4

  AST_LOAD_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cmd |=> (ld_req == '0)); // R4

  AST_GLOBAL_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cmd && (cmd_op == PB_OP_G_REG2WIP)) |=> (&ld_req)); // R6

  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> ((ld_req == '0) && !rd_valid)); // R8

  AST_BAD_OP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> (!busy && !rd_valid && (ld_req == '0))); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data)); // R10

endmodule

bind potbank_xfer potbank_xfer_chk #(
  .NUM_POTS  (NUM_POTS),
  .WIPER_W   (WIPER_W),
  .WR_CYCLES (WR_CYCLES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .ld_req    (ld_req)
);

// File: tb/potbank_xfer_tb_top.sv
`timescale 1ns/1ps
module potbank_xfer_tb_top;

  localparam int NP  = 2;
  localparam int W   = 6;
  localparam int NR  = 4;
  localparam int WRC = 12;
  localparam logic [NP*NR*W-1:0] INIT =
    {6'h31, 6'h15, 6'h2A, 6'h00, 6'h3F, 6'h23, 6'h12, 6'h05};

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic          cmd_pot;
  logic [1:0]    cmd_reg;
  logic [W-1:0]  cmd_wdata;
  logic [NP*W-1:0] wip_cur;
  logic          rd_valid;
  logic [W-1:0]  rd_data;
  logic [NP-1:0] ld_req;
  logic [NP*W-1:0] ld_val;
  logic          busy;

  int n_chk;
  int n_fail;
  logic [W-1:0] mdl [NP][NR];

  potbank_xfer #(
    .NUM_POTS  (NP),
    .WIPER_W   (W),
    .NUM_REGS  (NR),
    .WR_CYCLES (WRC),
    .INIT_REGS (INIT)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_pot   (cmd_pot),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .wip_cur   (wip_cur),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ld_req    (ld_req),
    .ld_val    (ld_val),
    .busy      (busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic pot, input logic [1:0] rg,
                       input logic [W-1:0] dat);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_pot   = pot;
    cmd_reg   = rg;
    cmd_wdata = dat;
  endtask

  task automatic issue(input logic [2:0] op, input logic pot, input logic [1:0] rg,
                       input logic [W-1:0] dat);
    @(negedge clk);
    drive(op, pot, rg, dat);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic count_busy(inout int n);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input int p, input int r, input string tag);
    issue(3'd0, 1'(p), 2'(r), '0);
    chk_eq({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    chk_eq({tag, " rd_data"}, 32'(rd_data), 32'(mdl[p][r]));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 ld_req in reset", 32'(ld_req), 32'h3);
    chk_eq("R1 ld_val in reset", 32'(ld_val), 32'({mdl[1][0], mdl[0][0]}));
    chk_eq("R1 busy in reset", 32'(busy), 32'd0);
    chk_eq("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 ld_req after first edge", 32'(ld_req), 32'h0);
    chk_eq("R10 ld_val held after recall", 32'(ld_val), 32'({mdl[1][0], mdl[0][0]}));
  endtask

  task automatic t_read_all;
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < NR; r++) begin
        read_chk(p, r, "R2 read");
      end
    end
    @(negedge clk);
    chk_eq("R10 rd_valid drops", 32'(rd_valid), 32'd0);
    chk_eq("R10 rd_data held", 32'(rd_data), 32'(mdl[1][3]));
  endtask

  task automatic t_write;
    int n;
    n = 0;
    issue(3'd1, 1'b1, 2'd2, 6'h2C);
    count_busy(n);
    chk_eq("R3 busy length", 32'(n), 32'(WRC));
    mdl[1][2] = 6'h2C;
    read_chk(1, 2, "R3 written reg");
    read_chk(0, 2, "R3 other pot same reg");
    read_chk(1, 1, "R3 neighbour reg");
  endtask

  task automatic t_single_load;
    issue(3'd2, 1'b0, 2'd3, '0);
    chk_eq("R4 ld_req one pot", 32'(ld_req), 32'h1);
    chk_eq("R4 ld_val pot0", 32'(ld_val[W-1:0]), 32'(mdl[0][3]));
    chk_eq("R10 ld_val pot1 held", 32'(ld_val[2*W-1:W]), 32'(mdl[1][0]));
    chk_eq("R4 no busy", 32'(busy), 32'd0);
    issue(3'd2, 1'b1, 2'd2, '0);
    chk_eq("R4 ld_req pot1", 32'(ld_req), 32'h2);
    chk_eq("R4 ld_val pot1", 32'(ld_val[2*W-1:W]), 32'(mdl[1][2]));
    @(negedge clk);
    chk_eq("R4 ld_req one cycle", 32'(ld_req), 32'h0);
  endtask

  task automatic t_single_store;
    int n;
    n = 0;
    wip_cur = {6'h1B, 6'h27};
    @(negedge clk);
    drive(3'd3, 1'b0, 2'd1, '0);
    @(negedge clk);
    cmd_valid = 1'b0;
    wip_cur = {6'h00, 6'h00};
    count_busy(n);
    chk_eq("R5 busy length", 32'(n), 32'(WRC));
    mdl[0][1] = 6'h27;
    read_chk(0, 1, "R5 stored wiper");
    read_chk(1, 1, "R5 other pot untouched");
  endtask

  task automatic t_global_load;
    issue(3'd4, 1'b1, 2'd2, '0);
    chk_eq("R6 ld_req both", 32'(ld_req), 32'h3);
    chk_eq("R6 ld_val both", 32'(ld_val), 32'({mdl[1][2], mdl[0][2]}));
    chk_eq("R6 no busy", 32'(busy), 32'd0);
  endtask

  task automatic t_global_store;
    int n;
    n = 0;
    wip_cur = {6'h0E, 6'h33};
    issue(3'd5, 1'b0, 2'd0, '0);
    count_busy(n);
    chk_eq("R7 busy length", 32'(n), 32'(WRC));
    mdl[0][0] = 6'h33;
    mdl[1][0] = 6'h0E;
    read_chk(0, 0, "R7 pot0 stored");
    read_chk(1, 0, "R7 pot1 stored");
    read_chk(0, 3, "R7 other reg untouched");
    issue(3'd4, 1'b0, 2'd0, '0);
    chk_eq("R7 recall via load", 32'(ld_val), 32'({6'h0E, 6'h33}));
  endtask

  task automatic t_busy_ignore;
    int n;
    n = 0;
    issue(3'd1, 1'b0, 2'd3, 6'h01);
    if (busy) n++;
    drive(3'd0, 1'b1, 2'd3, '0);
    @(negedge clk);
    chk_eq("R8 read ignored", 32'(rd_valid), 32'd0);
    if (busy) n++;
    drive(3'd2, 1'b0, 2'd0, '0);
    @(negedge clk);
    chk_eq("R8 load ignored", 32'(ld_req), 32'h0);
    if (busy) n++;
    drive(3'd1, 1'b1, 2'd3, 6'h10);
    @(negedge clk);
    cmd_valid = 1'b0;
    count_busy(n);
    chk_eq("R8 window not extended", 32'(n), 32'(WRC));
    mdl[0][3] = 6'h01;
    read_chk(0, 3, "R3 commit after window");
    read_chk(1, 3, "R8 write while busy dropped");
  endtask

  task automatic t_bad_op;
    issue(3'd6, 1'b0, 2'd1, 6'h3A);
    chk_eq("R9 op6 no read", 32'(rd_valid), 32'd0);
    chk_eq("R9 op6 no load", 32'(ld_req), 32'h0);
    chk_eq("R9 op6 no busy", 32'(busy), 32'd0);
    issue(3'd7, 1'b1, 2'd1, 6'h3A);
    chk_eq("R9 op7 no read", 32'(rd_valid), 32'd0);
    chk_eq("R9 op7 no load", 32'(ld_req), 32'h0);
    chk_eq("R9 op7 no busy", 32'(busy), 32'd0);
    read_chk(0, 1, "R9 reg unchanged p0");
    read_chk(1, 1, "R9 reg unchanged p1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    cmd_valid = 1'b0;
    cmd_op    = '0;
    cmd_pot   = 1'b0;
    cmd_reg   = '0;
    cmd_wdata = '0;
    wip_cur   = '0;
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < NR; r++) begin
        mdl[p][r] = INIT[(p*NR+r)*W +: W];
      end
    end
    t_reset();
    t_read_all();
    t_write();
    t_single_load();
    t_single_store();
    t_global_load();
    t_global_store();
    t_busy_ignore();
    t_bad_op();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule